// File: doc/BRIEF.md
# Virtual Timer Compare Unit

This block is a deadline timer that sits next to a free-running system counter. Software loads a compare value. The block then reports when the counter has reached or passed that value. The counter arrives on an input port. It keeps counting no matter how the timer is configured. The block only watches the counter and never drives it.

Software sees two registers. The first is the compare value. It is 64 bits wide and is always written and read as a low word and a high word in one transfer, so the two halves can never be seen out of step. The second is a control word with an enable bit, a mask bit and a read-only status bit. The status bit reports the deadline condition. The level interrupt output is the status gated by the mask.

A parameter sets the counter width. When the counter is narrower than 64 bits, only that many compare bits are stored. The remaining upper bits read as zero and take no writes. Both operands are zero-extended before every comparison.

Top module: `vtimer_cmp_unit`

## Requirements
- R1: After reset the compare value reads 0 (both words), the control word reads 0 and the interrupt output is low.
- R2: A write with register select 0 (compare) loads the high and low data words together in one clock edge; a read with select 0 returns the low word on the low read port and the high word on the high read port.
- R3: With enable set, the status is 1 one cycle after any cycle in which the zero-extended counter minus the zero-extended compare value is not negative. This includes the exact-equality cycle. The status is 0 one cycle after a cycle with counter = compare − 1.
- R4: The interrupt output is registered and is high one cycle after a cycle in which the deadline condition holds, enable is 1 and mask is 0.
- R5: With enable 0, the status and the interrupt read 0 one cycle later, whatever the counter value.
- R6: With mask 1, the interrupt output is 0 one cycle after the mask is taken, while the status still reads 1.
- R7: The status is recomputed every cycle, so rewriting the compare value to a value above the counter clears the status and the interrupt one cycle after the write.
- R8: For a counter narrower than 64 bits, the compare keeps only the counter's width. Upper compare bits read 0 and ignore writes, and the comparison uses the zero-extended stored value.
- R9: Control word layout (select 1, low word): bit 0 enable, bit 1 mask, bit 2 status. All other bits and the high word read 0. Writes to bit 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Free-running counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 compare, 1 control |
| wr_lo_i | input | 32 | Write data, low word |
| wr_hi_i | input | 32 | Write data, high word (compare only) |
| rd_sel_i | input | 1 | Read target: 0 compare, 1 control |
| rd_lo_o | output | 32 | Read data, low word |
| rd_hi_o | output | 32 | Read data, high word |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds two copies of the block side by side. One uses the default 64-bit counter width and the other a 20-bit counter. The wide copy covers the deadline at the very top of the 64-bit range, where a plain subtraction without the extra sign bit would wrap. The narrow copy shows the truncated compare storage: upper bits that read zero after a write of ones, and a deadline that follows the stored, zero-extended value instead of the written one.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int WORD_W   = 32;
  localparam int FULL_W   = 2 * WORD_W;
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;

  typedef enum logic {
    REG_CMP = 1'b0,
    REG_CTL = 1'b1
  } vtc_reg_e;

  // Deadline test: the counter minus the compare value must not be negative.
  // One extra bit holds the sign of the difference, so it never wraps.
  function automatic logic deadline_met(input logic [FULL_W-1:0] cnt,
                                        input logic [FULL_W-1:0] cmp);
    logic [FULL_W:0] diff;
    diff = {1'b0, cnt} - {1'b0, cmp};
    return ~diff[FULL_W];
  endfunction

  // Builds the control word read back by software.
  function automatic logic [WORD_W-1:0] pack_ctl(input logic en,
                                                 input logic mask,
                                                 input logic stat);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CTL_EN]   = en;
    w[CTL_MASK] = mask;
    w[CTL_STAT] = stat;
    return w;
  endfunction
endpackage

// File: rtl/vtc_cmp_store.sv
module vtc_cmp_store
  import vtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_lo_i,
  input  logic [WORD_W-1:0] wr_hi_i,
  output logic [FULL_W-1:0] cmp_ext_o
);
  logic [FULL_W-1:0] wr_word;
  logic [CNT_W-1:0]  cmp_q;

  assign wr_word = {wr_hi_i, wr_lo_i};

  always_ff @(posedge clk) begin
    if (!rst_n)    cmp_q <= '0;
    else if (wr_i) cmp_q <= wr_word[CNT_W-1:0];
  end

  generate
    if (CNT_W < FULL_W) begin : g_narrow
      logic unused_wr_upper;
      assign unused_wr_upper = ^wr_word[FULL_W-1:CNT_W];
      assign cmp_ext_o = {{(FULL_W-CNT_W){1'b0}}, cmp_q};

      // R8: the bits above the counter width always read zero
      a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_ext_o[FULL_W-1:CNT_W] == '0);
    end else begin : g_full
      assign cmp_ext_o = cmp_q;
    end
  endgenerate

  // R2: both words of a write land together on the next edge
  a_r2_pair_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cmp_q == $past(wr_word[CNT_W-1:0])));
endmodule

// File: rtl/vtc_ctl_reg.sv
module vtc_ctl_reg
  import vtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              en_o,
  output logic              mask_o
);
  logic en_q, mask_q;
  logic unused_ctl_bits;

  // Only the enable and mask bits are stored; the status bit position is dropped.
  assign unused_ctl_bits = ^{wr_data_i[WORD_W-1:CTL_MASK+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (wr_i) begin
      en_q   <= wr_data_i[CTL_EN];
      mask_q <= wr_data_i[CTL_MASK];
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  // R9: the enable bit holds its value unless a control write arrives
  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q) && $stable(mask_q));
endmodule

// File: rtl/vtc_cond_eval.sv
module vtc_cond_eval
  import vtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FULL_W-1:0] cmp_ext_i,
  input  logic              en_i,
  input  logic              mask_i,
  output logic              met_o,
  output logic              status_o,
  output logic              irq_o
);
  logic [FULL_W-1:0] cnt_ext;
  logic              fire;
  logic              status_q, irq_q;

  generate
    if (CNT_W < FULL_W) begin : g_zext
      assign cnt_ext = {{(FULL_W-CNT_W){1'b0}}, cnt_i};
    end else begin : g_full
      assign cnt_ext = cnt_i;
    end
  endgenerate

  assign met_o = deadline_met(cnt_ext, cmp_ext_i);
  assign fire  = met_o & en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= fire;
      irq_q    <= fire & ~mask_i;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R4: the interrupt never rises without a visible status
  a_r4_irq_implies_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> status_q);

  // R5: a disabled timer reports nothing on the next cycle
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !status_q && !irq_q);

  // R6: a masked cycle yields no interrupt on the next cycle
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_i |=> !irq_q);

  // R3: an enabled, met deadline shows up as status one cycle later
  a_r3_met_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && met_o) |=> status_q);
endmodule

// File: rtl/vtimer_cmp_unit.sv
module vtimer_cmp_unit
  import vtc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_lo_i,
  input  logic [WORD_W-1:0] wr_hi_i,
  input  logic              rd_sel_i,
  output logic [WORD_W-1:0] rd_lo_o,
  output logic [WORD_W-1:0] rd_hi_o,
  output logic              irq_o
);
  logic              wr_cmp, wr_ctl;
  logic [FULL_W-1:0] cmp_ext;
  logic              en, mask, met, status;

  assign wr_cmp = wr_en_i && (vtc_reg_e'(wr_sel_i) == REG_CMP);
  assign wr_ctl = wr_en_i && (vtc_reg_e'(wr_sel_i) == REG_CTL);

  vtc_cmp_store #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_cmp),
    .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .cmp_ext_o(cmp_ext)
  );

  vtc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctl), .wr_data_i(wr_lo_i),
    .en_o(en), .mask_o(mask)
  );

  vtc_cond_eval #(.CNT_W(CNT_W)) u_cond (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_ext_i(cmp_ext),
    .en_i(en), .mask_i(mask), .met_o(met), .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    if (vtc_reg_e'(rd_sel_i) == REG_CMP) begin
      rd_lo_o = cmp_ext[WORD_W-1:0];
      rd_hi_o = cmp_ext[FULL_W-1:WORD_W];
    end else begin
      rd_lo_o = pack_ctl(en, mask, status);
      rd_hi_o = '0;
    end
  end

  // R7: a compare write that moves the deadline past the counter clears status
  a_r7_rewrite_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!met) |=> !status);
endmodule

// File: tb/vtimer_cmp_unit_bench.sv
module vtimer_cmp_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 20;

  typedef struct {
    int          dut;
    logic [31:0] lo;
    logic [31:0] hi;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt_w = '0;
  logic [NW-1:0] cnt_n = '0;
  logic        wen_w = 1'b0, wen_n = 1'b0, wsel = 1'b0, rsel = 1'b0;
  logic [31:0] wlo = '0, whi = '0;
  logic [31:0] lo_w, hi_w, lo_n, hi_n;
  logic        irq_w, irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vtimer_cmp_unit u_vtimer_cmp_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .wr_en_i(wen_w), .wr_sel_i(wsel),
    .wr_lo_i(wlo), .wr_hi_i(whi), .rd_sel_i(rsel),
    .rd_lo_o(lo_w), .rd_hi_o(hi_w), .irq_o(irq_w)
  );

  vtimer_cmp_unit #(.CNT_W(NW)) u_vtimer_cmp_unit_nar (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_n), .wr_en_i(wen_n), .wr_sel_i(wsel),
    .wr_lo_i(wlo), .wr_hi_i(whi), .rd_sel_i(rsel),
    .rd_lo_o(lo_n), .rd_hi_o(hi_n), .irq_o(irq_n)
  );

  // Monitor: pops expectations and compares them against the live outputs.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] alo, ahi;
      logic        airq;
      e = sb.pop_front();
      alo  = (e.dut == 0) ? lo_w  : lo_n;
      ahi  = (e.dut == 0) ? hi_w  : hi_n;
      airq = (e.dut == 0) ? irq_w : irq_n;
      checks++;
      if (alo !== e.lo || ahi !== e.hi || airq !== e.irq) begin
        fails++;
        $display("FAIL %s: got lo=%h hi=%h irq=%b, expected lo=%h hi=%h irq=%b",
                 e.tag, alo, ahi, airq, e.lo, e.hi, e.irq);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int dut, input logic sel, input logic [31:0] lo,
                    input logic [31:0] hi);
    wsel = sel; wlo = lo; whi = hi;
    if (dut == 0) wen_w = 1'b1; else wen_n = 1'b1;
    step();
    wen_w = 1'b0; wen_n = 1'b0;
  endtask

  // Driver side of the scoreboard: selects the register and queues the expectation.
  task automatic expect_rd(input int dut, input logic sel, input logic [31:0] lo,
                           input logic [31:0] hi, input logic irq, input string tag);
    exp_t e;
    rsel = sel;
    e.dut = dut; e.lo = lo; e.hi = hi; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); #2;
  endtask

  function automatic logic [31:0] ctl(input logic en, input logic m, input logic s);
    return {29'd0, s, m, en};
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_rd(0, 0, 32'h0, 32'h0, 1'b0, "R1 compare after reset");
    expect_rd(0, 1, 32'h0, 32'h0, 1'b0, "R1 control after reset");

    // R2 pair write and readback
    wr(0, 0, 32'h0000_0010, 32'h0000_0001);
    expect_rd(0, 0, 32'h0000_0010, 32'h0000_0001, 1'b0, "R2 compare readback");

    // R3 cycle before the deadline
    wr(0, 1, 32'h1, 32'h0);
    cnt_w = 64'h1_0000_000F; step();
    expect_rd(0, 1, ctl(1, 0, 0), 32'h0, 1'b0, "R3 cycle before equality");
    // R3/R4 exact equality
    cnt_w = 64'h1_0000_0010; step();
    expect_rd(0, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R3 R4 exact equality");
    cnt_w = 64'h2_0000_0000; step();
    expect_rd(0, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R3 counter past deadline");

    // R6 mask keeps status, drops interrupt
    wr(0, 1, 32'h3, 32'h0); step();
    expect_rd(0, 1, ctl(1, 1, 1), 32'h0, 1'b0, "R6 masked");
    wr(0, 1, 32'h1, 32'h0); step();
    expect_rd(0, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R4 unmasked again");

    // R5 disable, R9 write to status bit ignored
    wr(0, 1, 32'h4, 32'h0); step();
    expect_rd(0, 1, ctl(0, 0, 0), 32'h0, 1'b0, "R5 R9 disabled, status write ignored");
    cnt_w = 64'h5_0000_0000; step();
    expect_rd(0, 1, ctl(0, 0, 0), 32'h0, 1'b0, "R5 counter moves while disabled");

    // R7 rewrite after firing
    wr(0, 1, 32'h1, 32'h0); step();
    expect_rd(0, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R7 firing before rewrite");
    wr(0, 0, 32'h0, 32'h0000_0009); step();
    expect_rd(0, 1, ctl(1, 0, 0), 32'h0, 1'b0, "R7 cleared after rewrite");

    // R3 top of range
    wr(0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cnt_w = 64'hFFFF_FFFF_FFFF_FFFE; step();
    expect_rd(0, 1, ctl(1, 0, 0), 32'h0, 1'b0, "R3 top range one below");
    cnt_w = 64'hFFFF_FFFF_FFFF_FFFF; step();
    expect_rd(0, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R3 top range equality");

    // R8 narrow counter
    wr(1, 0, 32'hFFF1_2345, 32'h0000_DEAD);
    expect_rd(1, 0, 32'h0001_2345, 32'h0, 1'b0, "R8 narrow upper bits read zero");
    wr(1, 1, 32'h1, 32'h0);
    cnt_n = 20'h12344; step();
    expect_rd(1, 1, ctl(1, 0, 0), 32'h0, 1'b0, "R8 narrow one below stored value");
    cnt_n = 20'h12345; step();
    expect_rd(1, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R8 narrow equality on stored value");
    cnt_n = 20'hFFFFF; step();
    expect_rd(1, 1, ctl(1, 0, 1), 32'h0, 1'b1, "R8 narrow counter at max");

    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule